// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block gathers the interrupt conditions of one UART channel into a single interrupt request line and a 6-bit identification code. Condition inputs come from the receiver, transmitter, modem-status logic, flow-control character matching and the two flow-control pins. They arrive as one-cycle pulses, except for the receive-error flag and the pins, which are levels. Each source keeps a pending latch. Each latch is cleared by its own event: a register read strobe, a data read or write strobe, or an opposing flow-control detection.

Each interrupt class has an enable bit. A disabled class is hidden from both the request line and the code, but its latch keeps its state. When an enable bit is set again, a condition that is still pending shows at once. The code is formed combinationally from the latches and enables, so it always names the highest-priority enabled source. A read of the identification register acts on the code visible in that same cycle.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset every latch is clear, `irqCode` is 6'b000001 and `irqOut` is low.
- R2: `irqCode` names the highest-priority enabled pending source. The order, highest first, is line status 6'b000110, receive time-out 6'b001100, receive data 6'b000100, transmit 6'b000010, modem status 6'b000000, Xoff/special character 6'b010000, flow-pin change 6'b100000. Code 6'b000001 means nothing is pending.
- R3: The line-status source is pending while `errInFifo` is high, and also after an `overrunPulse` until a `rdLineStat` strobe. Dropping `errInFifo` alone removes the error part.
- R4: The receive time-out and receive-data latches both clear on a `rdRxHold` strobe.
- R5: The transmit latch clears on `wrTxHold`. It also clears on `rdIdent` when the code in that same cycle is 6'b000010. A `rdIdent` while another code is shown leaves it pending.
- R6: The modem-status latch clears on `rdModemStat`.
- R7: A latch set by `xoffPulse` clears only on `xonPulse`. A latch set by `specialPulse` clears only on `rdLineStat`.
- R8: A low-to-high transition on `ctsPin` or `rtsPin` sets the flow-pin latch. It clears on `rdIdent` when the code in that cycle is 6'b100000.
- R9: When a set event and a clear event reach the same latch in one clock cycle, the latch ends up set.
- R10: `irqOut` is high exactly when some enabled source is pending. The `intEnable` bits are 0 receive (both time-out and data), 1 transmit, 2 line status, 3 modem status, 4 Xoff/special, 5 flow pins. Clearing an enable bit hides its source without clearing its latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intEnable | input | 6 | Per-class enable bits |
| errInFifo | input | 1 | Level: some character in the receive FIFO carries a framing, parity or break error |
| overrunPulse | input | 1 | Receive overrun occurred |
| rxTimeoutPulse | input | 1 | Stale data time-out in the receive FIFO |
| rxDataPulse | input | 1 | Receive data ready or trigger level reached |
| txEmptyPulse | input | 1 | Transmit holding empty or trigger reached |
| modemPulse | input | 1 | Modem status input changed |
| xoffPulse | input | 1 | Xoff character detected |
| xonPulse | input | 1 | Xon character detected |
| specialPulse | input | 1 | Special character detected |
| ctsPin | input | 1 | Clear-to-send pin level, active low |
| rtsPin | input | 1 | Request-to-send pin level, active low |
| rdIdent | input | 1 | Read strobe of the identification register |
| rdLineStat | input | 1 | Read strobe of the line status register |
| rdRxHold | input | 1 | Read strobe of the receive holding register |
| wrTxHold | input | 1 | Write strobe of the transmit holding register |
| rdModemStat | input | 1 | Read strobe of the modem status register |
| irqOut | output | 1 | Interrupt request, active high |
| irqCode | output | 6 | Identification code of the highest-priority pending source |

## Verification
The bench builds the block with its default parameter, in which the flow-pin history resets to the inactive high level. With that setting, a pin held low through reset and raised afterwards gives exactly one set event, and pins already high at reset give none. A directed phase walks each clear rule, the priority order and the same-cycle set-and-clear cases. Three thousand cycles of random pulses, strobes, enables and pin levels follow. Those cycles reach collisions between identification reads and changing codes that the directed phase does not construct by hand.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int CODE_W   = 6;
  localparam int NUM_EN   = 6;
  localparam int NUM_LAT  = 8;
  localparam int NUM_LVL  = 7;
  localparam int NUM_PINS = 2;

  // enable bit positions
  localparam int EN_RX   = 0;
  localparam int EN_TX   = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MOD  = 3;
  localparam int EN_CHR  = 4;
  localparam int EN_PIN  = 5;

  // latch positions
  localparam int L_OVR  = 0;
  localparam int L_TO   = 1;
  localparam int L_RD   = 2;
  localparam int L_TX   = 3;
  localparam int L_MOD  = 4;
  localparam int L_XOFF = 5;
  localparam int L_SPEC = 6;
  localparam int L_PIN  = 7;

  localparam logic [CODE_W-1:0] CODE_NONE = 6'b000001;
  localparam logic [CODE_W-1:0] CODE_LINE = 6'b000110;
  localparam logic [CODE_W-1:0] CODE_TO   = 6'b001100;
  localparam logic [CODE_W-1:0] CODE_RD   = 6'b000100;
  localparam logic [CODE_W-1:0] CODE_TX   = 6'b000010;
  localparam logic [CODE_W-1:0] CODE_MOD  = 6'b000000;
  localparam logic [CODE_W-1:0] CODE_CHR  = 6'b010000;
  localparam logic [CODE_W-1:0] CODE_PIN  = 6'b100000;

  typedef struct packed {
    logic lsrRead;
    logic rhrRead;
    logic thrWrite;
    logic msrRead;
    logic xonSeen;
    logic txAck;
    logic pinAck;
  } clrStrobe_t;

  function automatic logic [CODE_W-1:0] levelCode(input int lvl);
    case (lvl)
      0:       return CODE_LINE;
      1:       return CODE_TO;
      2:       return CODE_RD;
      3:       return CODE_TX;
      4:       return CODE_MOD;
      5:       return CODE_CHR;
      6:       return CODE_PIN;
      default: return CODE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
  import uart_irq_pkg::*;
#(
  parameter bit RESET_PIN_LEVEL = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                overrunPulse,
  input  logic                rxTimeoutPulse,
  input  logic                rxDataPulse,
  input  logic                txEmptyPulse,
  input  logic                modemPulse,
  input  logic                xoffPulse,
  input  logic                specialPulse,
  input  logic [NUM_PINS-1:0] flowPins,
  input  clrStrobe_t          clr,
  output logic [NUM_LAT-1:0]  pend
);

  logic [NUM_PINS-1:0] pinPrev;
  logic [NUM_PINS-1:0] pinRise;
  logic [NUM_LAT-1:0]  setVec;
  logic [NUM_LAT-1:0]  clrVec;

  // history of each flow pin, rising edge = active to inactive
  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pinPrev[k] <= RESET_PIN_LEVEL;
      else       pinPrev[k] <= flowPins[k];
    end
    assign pinRise[k] = flowPins[k] & ~pinPrev[k];
  end

  always_comb begin
    setVec         = '0;
    setVec[L_OVR]  = overrunPulse;
    setVec[L_TO]   = rxTimeoutPulse;
    setVec[L_RD]   = rxDataPulse;
    setVec[L_TX]   = txEmptyPulse;
    setVec[L_MOD]  = modemPulse;
    setVec[L_XOFF] = xoffPulse;
    setVec[L_SPEC] = specialPulse;
    setVec[L_PIN]  = |pinRise;
  end

  always_comb begin
    clrVec         = '0;
    clrVec[L_OVR]  = clr.lsrRead;
    clrVec[L_TO]   = clr.rhrRead;
    clrVec[L_RD]   = clr.rhrRead;
    clrVec[L_TX]   = clr.thrWrite | clr.txAck;
    clrVec[L_MOD]  = clr.msrRead;
    clrVec[L_XOFF] = clr.xonSeen;
    clrVec[L_SPEC] = clr.lsrRead;
    clrVec[L_PIN]  = clr.pinAck;
  end

  // set dominates clear
  for (genvar i = 0; i < NUM_LAT; i++) begin : g_lat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pend[i] <= 1'b0;
      else       pend[i] <= setVec[i] | (pend[i] & ~clrVec[i]);
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
      setVec[i] |=> pend[i]);
  end

  p_modem_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clr.msrRead && !modemPulse) |=> !pend[L_MOD]);

  p_xon_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clr.xonSeen && !xoffPulse) |=> !pend[L_XOFF]);

  p_xoff_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pend[L_XOFF] && !clr.xonSeen) |=> pend[L_XOFF]);

  p_rhr_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clr.rhrRead && !rxTimeoutPulse && !rxDataPulse) |=> (!pend[L_TO] && !pend[L_RD]));

  p_pin_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|(flowPins & ~pinPrev)) |=> pend[L_PIN]);

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_LAT-1:0] pend,
  input  logic [NUM_EN-1:0]  intEnable,
  input  logic               errInFifo,
  input  logic               rdIdent,
  input  logic               rdLineStat,
  input  logic               rdRxHold,
  input  logic               wrTxHold,
  input  logic               rdModemStat,
  input  logic               xonPulse,
  output clrStrobe_t         clr,
  output logic [CODE_W-1:0]  irqCode,
  output logic               irqOut
);

  logic [NUM_LVL-1:0] lvlReq;

  always_comb begin
    lvlReq    = '0;
    lvlReq[0] = intEnable[EN_LINE] & (errInFifo | pend[L_OVR]);
    lvlReq[1] = intEnable[EN_RX]   & pend[L_TO];
    lvlReq[2] = intEnable[EN_RX]   & pend[L_RD];
    lvlReq[3] = intEnable[EN_TX]   & pend[L_TX];
    lvlReq[4] = intEnable[EN_MOD]  & pend[L_MOD];
    lvlReq[5] = intEnable[EN_CHR]  & (pend[L_XOFF] | pend[L_SPEC]);
    lvlReq[6] = intEnable[EN_PIN]  & pend[L_PIN];
  end

  // lowest index wins: scan from the bottom of the order upward
  always_comb begin
    irqCode = CODE_NONE;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (lvlReq[i]) irqCode = levelCode(i);
    end
  end

  assign irqOut = |lvlReq;

  always_comb begin
    clr          = '0;
    clr.lsrRead  = rdLineStat;
    clr.rhrRead  = rdRxHold;
    clr.thrWrite = wrTxHold;
    clr.msrRead  = rdModemStat;
    clr.xonSeen  = xonPulse;
    clr.txAck    = rdIdent && (irqCode == CODE_TX);
    clr.pinAck   = rdIdent && (irqCode == CODE_PIN);
  end

  p_idle_code_r1: assert property (@(posedge clk) disable iff (!rstN)
    irqCode[0] |-> !irqOut);

  p_line_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable[EN_LINE] && errInFifo) |-> (irqCode == CODE_LINE));

  p_timeout_over_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable[EN_RX] && pend[L_TO] && !intEnable[EN_LINE]) |-> (irqCode == CODE_TO));

  p_mask_hides_r10: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable == '0) |-> (!irqOut && irqCode == CODE_NONE));

  p_tx_other_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdent && pend[L_TX] && irqCode != CODE_TX && !wrTxHold) |=> pend[L_TX]);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter bit RESET_PIN_LEVEL = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  intEnable,
  input  logic        errInFifo,
  input  logic        overrunPulse,
  input  logic        rxTimeoutPulse,
  input  logic        rxDataPulse,
  input  logic        txEmptyPulse,
  input  logic        modemPulse,
  input  logic        xoffPulse,
  input  logic        xonPulse,
  input  logic        specialPulse,
  input  logic        ctsPin,
  input  logic        rtsPin,
  input  logic        rdIdent,
  input  logic        rdLineStat,
  input  logic        rdRxHold,
  input  logic        wrTxHold,
  input  logic        rdModemStat,
  output logic        irqOut,
  output logic [5:0]  irqCode
);

  logic [NUM_LAT-1:0] pend;
  clrStrobe_t         clr;

  irq_latch_bank #(.RESET_PIN_LEVEL(RESET_PIN_LEVEL)) uLatch (
    .clk            (clk),
    .rstN           (rstN),
    .overrunPulse   (overrunPulse),
    .rxTimeoutPulse (rxTimeoutPulse),
    .rxDataPulse    (rxDataPulse),
    .txEmptyPulse   (txEmptyPulse),
    .modemPulse     (modemPulse),
    .xoffPulse      (xoffPulse),
    .specialPulse   (specialPulse),
    .flowPins       ({rtsPin, ctsPin}),
    .clr            (clr),
    .pend           (pend)
  );

  irq_prio_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .pend        (pend),
    .intEnable   (intEnable),
    .errInFifo   (errInFifo),
    .rdIdent     (rdIdent),
    .rdLineStat  (rdLineStat),
    .rdRxHold    (rdRxHold),
    .wrTxHold    (wrTxHold),
    .rdModemStat (rdModemStat),
    .xonPulse    (xonPulse),
    .clr         (clr),
    .irqCode     (irqCode),
    .irqOut      (irqOut)
  );

  p_overrun_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdLineStat && !overrunPulse && !errInFifo && intEnable[2]) |=> (irqCode != 6'b000110 || errInFifo));

endmodule

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/100ps
module uart_irq_ident_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] intEnable = '0;
  logic errInFifo = 0, overrunPulse = 0, rxTimeoutPulse = 0, rxDataPulse = 0;
  logic txEmptyPulse = 0, modemPulse = 0, xoffPulse = 0, xonPulse = 0, specialPulse = 0;
  logic ctsPin = 0, rtsPin = 0;
  logic rdIdent = 0, rdLineStat = 0, rdRxHold = 0, wrTxHold = 0, rdModemStat = 0;
  logic       irqOut;
  logic [5:0] irqCode;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ident uut (.*);

  // behavioural reference state
  bit mOvr, mTo, mRd, mTx, mMod, mXoff, mSpec, mPin;
  bit prevCts = 1, prevRts = 1;

  function automatic logic [5:0] refCode();
    if (intEnable[2] && (errInFifo || mOvr)) return 6'b000110;
    if (intEnable[0] && mTo)                 return 6'b001100;
    if (intEnable[0] && mRd)                 return 6'b000100;
    if (intEnable[1] && mTx)                 return 6'b000010;
    if (intEnable[3] && mMod)                return 6'b000000;
    if (intEnable[4] && (mXoff || mSpec))    return 6'b010000;
    if (intEnable[5] && mPin)                return 6'b100000;
    return 6'b000001;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      {mOvr, mTo, mRd, mTx, mMod, mXoff, mSpec, mPin} = '0;
      prevCts = 1; prevRts = 1;
    end else begin
      logic [5:0] c;
      bit rise;
      c = refCode();
      rise = (ctsPin && !prevCts) || (rtsPin && !prevRts);
      mOvr  = overrunPulse   || (mOvr  && !rdLineStat);
      mTo   = rxTimeoutPulse || (mTo   && !rdRxHold);
      mRd   = rxDataPulse    || (mRd   && !rdRxHold);
      mTx   = txEmptyPulse   || (mTx   && !(wrTxHold || (rdIdent && c == 6'b000010)));
      mMod  = modemPulse     || (mMod  && !rdModemStat);
      mXoff = xoffPulse      || (mXoff && !xonPulse);
      mSpec = specialPulse   || (mSpec && !rdLineStat);
      mPin  = rise           || (mPin  && !(rdIdent && c == 6'b100000));
      prevCts = ctsPin; prevRts = rtsPin;
    end
  end

  // per-cycle comparison, away from both edges
  always @(negedge clk) begin
    #1.5;
    if (rstN && !done) begin
      logic [5:0] e;
      e = refCode();
      checks++;
      if (irqCode !== e) begin
        failures++;
        $display("FAIL R2 cycle model: irqCode=%b expected=%b", irqCode, e);
      end
      checks++;
      if (irqOut !== (e != 6'b000001)) begin
        failures++;
        $display("FAIL R10 cycle model: irqOut=%b expected=%b", irqOut, e != 6'b000001);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic clearStrobes();
    {overrunPulse, rxTimeoutPulse, rxDataPulse, txEmptyPulse, modemPulse} = '0;
    {xoffPulse, xonPulse, specialPulse} = '0;
    {rdIdent, rdLineStat, rdRxHold, wrTxHold, rdModemStat} = '0;
  endtask

  task automatic step();
    tick();
    clearStrobes();
  endtask

  task automatic chk(input string req, input logic [5:0] expCode, input logic expIrq);
    checks++;
    if (irqCode !== expCode || irqOut !== expIrq) begin
      failures++;
      $display("FAIL %s: code=%b irq=%b expected code=%b irq=%b",
               req, irqCode, irqOut, expCode, expIrq);
    end
  endtask

  task automatic finishUp();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #800000;
    checks++;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finishUp();
  end

  initial begin
    repeat (3) tick();
    chk("R1 during reset", 6'b000001, 1'b0);
    rstN = 1;
    tick();
    chk("R1 after reset", 6'b000001, 1'b0);
    intEnable = 6'h3F;
    tick();
    chk("R1 enabled idle", 6'b000001, 1'b0);

    // R8 pin rise then identification read
    ctsPin = 1; step();
    chk("R8 cts rise", 6'b100000, 1'b1);
    rdIdent = 1; step();
    chk("R8 ident read clears", 6'b000001, 1'b0);
    rtsPin = 1; step();
    chk("R8 rts rise", 6'b100000, 1'b1);
    rdIdent = 1; step();
    ctsPin = 0; rtsPin = 0; step();
    chk("R8 falling gives nothing", 6'b000001, 1'b0);

    // R7 and R6
    xoffPulse = 1; step();
    chk("R7 xoff set", 6'b010000, 1'b1);
    rdLineStat = 1; step();
    chk("R7 lsr read leaves xoff", 6'b010000, 1'b1);
    modemPulse = 1; step();
    chk("R2 modem above xoff", 6'b000000, 1'b1);
    rdModemStat = 1; step();
    chk("R6 msr read clears", 6'b010000, 1'b1);
    xonPulse = 1; step();
    chk("R7 xon clears", 6'b000001, 1'b0);
    specialPulse = 1; step();
    chk("R7 special set", 6'b010000, 1'b1);
    xonPulse = 1; step();
    chk("R7 xon leaves special", 6'b010000, 1'b1);
    rdLineStat = 1; step();
    chk("R7 lsr read clears special", 6'b000001, 1'b0);

    // R5
    txEmptyPulse = 1; step();
    rxDataPulse = 1; step();
    chk("R2 rx data above tx", 6'b000100, 1'b1);
    rdIdent = 1; step();
    chk("R5 ident read on other code", 6'b000100, 1'b1);
    rdRxHold = 1; step();
    chk("R5 tx still pending", 6'b000010, 1'b1);
    wrTxHold = 1; step();
    chk("R5 thr write clears", 6'b000001, 1'b0);
    txEmptyPulse = 1; step();
    rdIdent = 1; step();
    chk("R5 ident read on tx clears", 6'b000001, 1'b0);

    // R3 and R4
    rxDataPulse = 1; rxTimeoutPulse = 1; step();
    chk("R2 timeout above data", 6'b001100, 1'b1);
    errInFifo = 1; tick();
    chk("R3 error level highest", 6'b000110, 1'b1);
    errInFifo = 0; tick();
    chk("R3 error level removed", 6'b001100, 1'b1);
    rdRxHold = 1; step();
    chk("R4 rhr read clears both", 6'b000001, 1'b0);
    overrunPulse = 1; step();
    chk("R3 overrun latched", 6'b000110, 1'b1);
    rdRxHold = 1; step();
    chk("R3 overrun holds", 6'b000110, 1'b1);
    rdLineStat = 1; step();
    chk("R3 lsr read clears overrun", 6'b000001, 1'b0);

    // R9
    modemPulse = 1; rdModemStat = 1; step();
    chk("R9 set beats clear", 6'b000000, 1'b1);
    xoffPulse = 1; xonPulse = 1; step();
    rdModemStat = 1; step();
    chk("R9 xoff set beats xon", 6'b010000, 1'b1);
    xonPulse = 1; step();

    // R10
    modemPulse = 1; step();
    intEnable = 6'b110111; tick();
    chk("R10 masked modem hidden", 6'b000001, 1'b0);
    intEnable = 6'h3F; tick();
    chk("R10 unmasked modem returns", 6'b000000, 1'b1);
    intEnable = '0; rxDataPulse = 1; step();
    chk("R10 all masked", 6'b000001, 1'b0);
    intEnable = 6'b000001; tick();
    chk("R10 receive bit zero", 6'b000100, 1'b1);
    intEnable = 6'h3F; rdRxHold = 1; rdModemStat = 1; step();
    chk("R10 cleared", 6'b000001, 1'b0);

    // random phase against the reference model
    for (int n = 0; n < 3000; n++) begin
      overrunPulse   = ($urandom_range(0, 19) == 0);
      rxTimeoutPulse = ($urandom_range(0, 9) == 0);
      rxDataPulse    = ($urandom_range(0, 9) == 0);
      txEmptyPulse   = ($urandom_range(0, 7) == 0);
      modemPulse     = ($urandom_range(0, 9) == 0);
      xoffPulse      = ($urandom_range(0, 11) == 0);
      xonPulse       = ($urandom_range(0, 11) == 0);
      specialPulse   = ($urandom_range(0, 15) == 0);
      rdIdent        = ($urandom_range(0, 3) == 0);
      rdLineStat     = ($urandom_range(0, 7) == 0);
      rdRxHold       = ($urandom_range(0, 7) == 0);
      wrTxHold       = ($urandom_range(0, 9) == 0);
      rdModemStat    = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 7) == 0) ctsPin = ~ctsPin;
      if ($urandom_range(0, 7) == 0) rtsPin = ~rtsPin;
      if ($urandom_range(0, 15) == 0) errInFifo = ~errInFifo;
      if ($urandom_range(0, 31) == 0) intEnable = 6'($urandom);
      tick();
    end
    clearStrobes();
    tick();
    finishUp();
  end

endmodule